// File: doc/BRIEF.md
# Vector Element Sign-Mask Extractor

This unit sits beside a vector execution pipe. It watches a 32-bit instruction word and its valid strobe. When the word belongs to the sign-mask extract group, it splits the accompanying 128-bit vector operand into elements of the selected size and gathers the most significant bit of every element. The gathered bits form a compact scalar mask, zero-extended to 64 bits, and the scalar register file can consume it.

Elements are counted from the high end of the vector. The sign bit of the top element therefore becomes the highest mask bit, and the sign bit of the bottom element becomes result bit 0. If the vector facility is switched off, a recognised instruction produces an illegal flag and no result. Words outside the handled selector range pass through silently, so other units can claim them. Every outcome appears one clock after the instruction is presented.

The outcome register is a three-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing is reported. |
| `ST_RESULT` | A mask result is valid. |
| `ST_TRAP` | The illegal flag is raised. |

The machine moves on every clock edge, and the next state depends only on the instruction presented in that cycle:

| Transition | Condition | Target |
|---|---|---|
| accept | a handled instruction with the facility enabled | `ST_RESULT` |
| trap | a handled instruction with the facility disabled | `ST_TRAP` |
| drop | no valid strobe, or an unhandled word | `ST_IDLE` |

Synchronous reset forces `ST_IDLE`.

Top module: `elm_sign_extract`

## Requirements
- R1: An instruction is handled only when all of the following hold: the valid strobe is high, bits 31:26 equal 000100, bits 10:0 equal 11001000010, and the selector in bits 20:16 is one of 01000, 01001, 01010, 01011 or 01100. The outcome of that instruction is presented on the outputs one clock after it is presented on the inputs.
- R2: Selector 01000 (bytes) produces 16 mask bits. Result bit k equals vector bit 8k+7.
- R3: Selector 01001 (halfwords) produces 8 mask bits. Result bit k equals vector bit 16k+15.
- R4: Selector 01010 (words) produces 4 mask bits. Result bit k equals vector bit 32k+31.
- R5: Selector 01011 (doublewords) produces 2 mask bits. Result bit k equals vector bit 64k+63.
- R6: Selector 01100 (quadword) produces a single mask bit. Result bit 0 equals vector bit 127.
- R7: Vector bits other than the element sign bits have no effect on the result.
- R8: All result bits above the mask width of the selected size are zero, so no result ever has a bit set above bit 15.
- R9: A handled instruction that arrives while vector enable is low sets the illegal flag. Its result valid stays low and its result data is zero.
- R10: Two kinds of word leave both flags low and the data zero on the following cycle: a word with another selector value in the same group, and a word that does not match the opcode fields.
- R11: The destination index from instruction bits 25:21 is presented with the result.
- R12: Synchronous active-high reset clears both flags, even if a handled instruction is presented during reset.
- R13: A cycle without the valid strobe leaves both flags low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_valid_i | input | 1 | Instruction strobe |
| insn_i | input | 32 | Instruction word |
| vec_i | input | 128 | Vector source operand |
| vec_en_i | input | 1 | Vector facility enabled |
| res_valid_o | output | 1 | Result valid |
| res_illegal_o | output | 1 | Illegal/unavailable flag |
| res_data_o | output | 64 | Zero-extended mask result |
| res_dest_o | output | 5 | Destination register index |

## Verification
Two functions can share one cycle: the output register presents the completed result of one instruction while the decoder makes the trap decision for the next. The bench provokes this by issuing a legal byte extract and then, on the very next edge, the same word with vector enable low. It expects the correct mask with valid high first, and then the illegal flag alone with data cleared. A second overlap, a reset asserted in the same cycle as a legal instruction, is checked to yield both flags low.

// File: rtl/elm_pkg.sv
package elm_pkg;

    localparam logic [5:0]  MAJOR_OP = 6'b000100;
    localparam logic [10:0] EXT_OP   = 11'b11001000010;

    localparam logic [4:0] SEL_B = 5'b01000;
    localparam logic [4:0] SEL_H = 5'b01001;
    localparam logic [4:0] SEL_W = 5'b01010;
    localparam logic [4:0] SEL_D = 5'b01011;
    localparam logic [4:0] SEL_Q = 5'b01100;

    localparam int NUM_SIZES = 5;

    typedef enum logic [2:0] {
        SZ_B = 3'd0,
        SZ_H = 3'd1,
        SZ_W = 3'd2,
        SZ_D = 3'd3,
        SZ_Q = 3'd4
    } elm_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_TRAP   = 2'd2
    } elm_state_e;

    typedef struct packed {
        logic       hit;
        logic       known;
        elm_size_e  size;
        logic [4:0] dst;
    } elm_dec_t;

endpackage

// File: rtl/elm_decode.sv
module elm_decode
    import elm_pkg::*;
(
    input  logic [31:0] insn_i,
    output elm_dec_t    dec_o
);

    logic unused_src_field;
    assign unused_src_field = ^insn_i[15:11];

    always_comb begin
        dec_o       = '0;
        dec_o.dst   = insn_i[25:21];
        dec_o.hit   = (insn_i[31:26] == MAJOR_OP) && (insn_i[10:0] == EXT_OP);
        dec_o.size  = SZ_B;
        dec_o.known = 1'b0;
        unique case (insn_i[20:16])
            SEL_B: begin dec_o.size = SZ_B; dec_o.known = dec_o.hit; end
            SEL_H: begin dec_o.size = SZ_H; dec_o.known = dec_o.hit; end
            SEL_W: begin dec_o.size = SZ_W; dec_o.known = dec_o.hit; end
            SEL_D: begin dec_o.size = SZ_D; dec_o.known = dec_o.hit; end
            SEL_Q: begin dec_o.size = SZ_Q; dec_o.known = dec_o.hit; end
            default: begin dec_o.size = SZ_B; dec_o.known = 1'b0; end
        endcase
    end

endmodule

// File: rtl/elm_pack.sv
module elm_pack #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8,
    parameter int OUT_W  = 64
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [OUT_W-1:0] mask_o
);

    localparam int N_ELEM = VEC_W / ELEM_W;

    logic unused_body_bits;
    assign unused_body_bits = ^vec_i;

    for (genvar k = 0; k < N_ELEM; k++) begin : g_tap
        assign mask_o[k] = vec_i[k*ELEM_W + ELEM_W - 1];
    end

    if (N_ELEM < OUT_W) begin : g_fill
        assign mask_o[OUT_W-1:N_ELEM] = '0;
    end

endmodule

// File: rtl/elm_sign_extract.sv
module elm_sign_extract
    import elm_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int RES_W  = 64,
    parameter int INSN_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [VEC_W-1:0]  vec_i,
    input  logic              vec_en_i,
    output logic              res_valid_o,
    output logic              res_illegal_o,
    output logic [RES_W-1:0]  res_data_o,
    output logic [IDX_W-1:0]  res_dest_o
);

    localparam int MAX_BITS = VEC_W / 8;

    elm_dec_t   dec;
    elm_state_e state_q, state_d;
    logic [RES_W-1:0] masks [NUM_SIZES];
    logic [RES_W-1:0] mask_sel;
    logic [RES_W-1:0] data_q;
    logic [IDX_W-1:0] dst_q;

    elm_decode i_dec (
        .insn_i (insn_i[31:0]),
        .dec_o  (dec)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        elm_pack #(
            .VEC_W  (VEC_W),
            .ELEM_W (8 << g),
            .OUT_W  (RES_W)
        ) i_pack (
            .vec_i  (vec_i),
            .mask_o (masks[g])
        );
    end

    always_comb begin
        unique case (dec.size)
            SZ_B:    mask_sel = masks[0];
            SZ_H:    mask_sel = masks[1];
            SZ_W:    mask_sel = masks[2];
            SZ_D:    mask_sel = masks[3];
            SZ_Q:    mask_sel = masks[4];
            default: mask_sel = '0;
        endcase
    end

    // next-state selection
    always_comb begin
        if (insn_valid_i && dec.known) begin
            state_d = vec_en_i ? ST_RESULT : ST_TRAP;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // state register and payload
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == ST_RESULT) ? mask_sel : '0;
            if (insn_valid_i && dec.known) begin
                dst_q <= dec.dst;
            end
        end
    end

    // outputs from state
    always_comb begin
        res_valid_o   = 1'b0;
        res_illegal_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin res_valid_o = 1'b0; res_illegal_o = 1'b0; end
            ST_RESULT: begin res_valid_o = 1'b1; res_illegal_o = 1'b0; end
            ST_TRAP:   begin res_valid_o = 1'b0; res_illegal_o = 1'b1; end
            default:   begin res_valid_o = 1'b0; res_illegal_o = 1'b0; end
        endcase
    end

    assign res_data_o = data_q;
    assign res_dest_o = dst_q;

    assert_trap_R9: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && dec.known && !vec_en_i) |=>
        (res_illegal_o && !res_valid_o && res_data_o == '0));

    assert_unhandled_R10: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && !dec.known) |=> (!res_valid_o && !res_illegal_o));

    assert_quad_R6: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && dec.known && vec_en_i && dec.size == SZ_Q) |=>
        (res_data_o == {{(RES_W-1){1'b0}}, $past(vec_i[VEC_W-1])}));

    assert_zero_ext_R8: assert property (@(posedge clk) disable iff (rst)
        res_data_o[RES_W-1:MAX_BITS] == '0);

    assert_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !insn_valid_i |=> (!res_valid_o && !res_illegal_o));

    assert_dest_R11: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_i && dec.known && vec_en_i) |=>
        (res_dest_o == $past(insn_i[25:21])));

endmodule

// File: tb/test_elm_sign_extract.sv
`timescale 1ns/1ps
module test_elm_sign_extract;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         insn_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [127:0] vec = '0;
    logic         vec_en = 1'b1;
    logic         res_valid, res_illegal;
    logic [63:0]  res_data;
    logic [4:0]   res_dest;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    elm_sign_extract i_elm_sign_extract (
        .clk           (clk),
        .rst           (rst),
        .insn_valid_i  (insn_valid),
        .insn_i        (insn),
        .vec_i         (vec),
        .vec_en_i      (vec_en),
        .res_valid_o   (res_valid),
        .res_illegal_o (res_illegal),
        .res_data_o    (res_data),
        .res_dest_o    (res_dest)
    );

    function automatic logic [31:0] mk(input logic [4:0] dst, input logic [4:0] sel,
                                       input logic [4:0] src);
        return {6'b000100, dst, sel, src, 11'b11001000010};
    endfunction

    function automatic logic [63:0] ref_mask(input logic [127:0] v, input int sz);
        int w = 8 << sz;
        int n = 16 >> sz;
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = v[127 - i*w];
        return r;
    endfunction

    function automatic string tag_of(input int sz);
        case (sz)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] v, input logic en);
        @(negedge clk);
        insn_valid = 1'b1; insn = w; vec = v; vec_en = en;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic expect_result(input string tag, input logic [63:0] exp);
        check(res_valid && !res_illegal && res_data == exp, tag, res_data, exp);
    endtask

    task automatic t_reset();
        insn_valid = 1'b1; insn = mk(5'd1, 5'b01000, 5'd2); vec = '1;
        repeat (3) @(negedge clk);
        check(!res_valid && !res_illegal, "R12 reset flags",
              {62'd0, res_valid, res_illegal}, 64'd0);
        insn_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_fill();
        for (int sz = 0; sz < 5; sz++) begin
            issue(mk(5'd3, 5'b01000 + 5'(sz), 5'd4), '1, 1'b1);
            expect_result({tag_of(sz), " R1 all ones"}, ref_mask('1, sz));
            issue(mk(5'd3, 5'b01000 + 5'(sz), 5'd4), '0, 1'b1);
            expect_result({tag_of(sz), " all zeros"}, 64'd0);
        end
    endtask

    task automatic t_alternate();
        for (int sz = 0; sz < 5; sz++) begin
            for (int ph = 0; ph < 2; ph++) begin
                logic [127:0] v = rnd128();
                int w = 8 << sz;
                for (int i = 0; i < (16 >> sz); i++) v[127 - i*w] = ((i + ph) % 2) != 0;
                issue(mk(5'd7, 5'b01000 + 5'(sz), 5'd0), v, 1'b1);
                expect_result({tag_of(sz), " alternating"}, ref_mask(v, sz));
            end
        end
    endtask

    task automatic t_random();
        for (int sz = 0; sz < 5; sz++) begin
            for (int n = 0; n < 6; n++) begin
                logic [127:0] v = rnd128();
                issue(mk(5'(n), 5'b01000 + 5'(sz), 5'd9), v, 1'b1);
                expect_result({tag_of(sz), " random R8"}, ref_mask(v, sz));
            end
        end
    endtask

    task automatic t_body_bits();
        for (int sz = 0; sz < 5; sz++) begin
            logic [127:0] v = '1;
            int w = 8 << sz;
            for (int i = 0; i < (16 >> sz); i++) v[127 - i*w] = 1'b0;
            issue(mk(5'd2, 5'b01000 + 5'(sz), 5'd2), v, 1'b1);
            expect_result("R7 non-sign ones", 64'd0);
            issue(mk(5'd2, 5'b01000 + 5'(sz), 5'd2), ~v, 1'b1);
            expect_result("R7 sign only", ref_mask('1, sz));
        end
    endtask

    task automatic t_disabled();
        issue(mk(5'd5, 5'b01010, 5'd1), '1, 1'b0);
        check(res_illegal && !res_valid && res_data == 0, "R9 disabled",
              res_data, 64'd0);
    endtask

    task automatic t_unhandled();
        logic [31:0] bad = mk(5'd5, 5'b01000, 5'd1);
        issue(mk(5'd5, 5'b00000, 5'd1), '1, 1'b1);
        check(!res_valid && !res_illegal && res_data == 0, "R10 sel 00000",
              res_data, 64'd0);
        issue(mk(5'd5, 5'b01101, 5'd1), '1, 1'b0);
        check(!res_valid && !res_illegal && res_data == 0, "R10 sel 01101",
              res_data, 64'd0);
        bad[31:26] = 6'b000101;
        issue(bad, '1, 1'b1);
        check(!res_valid && !res_illegal, "R10 R1 wrong major",
              {62'd0, res_valid, res_illegal}, 64'd0);
        bad = mk(5'd5, 5'b01000, 5'd1);
        bad[0] = 1'b1;
        issue(bad, '1, 1'b1);
        check(!res_valid && !res_illegal, "R10 R1 wrong extended op",
              {62'd0, res_valid, res_illegal}, 64'd0);
    endtask

    task automatic t_dest();
        issue(mk(5'd31, 5'b01001, 5'd0), '1, 1'b1);
        check(res_valid && res_dest == 5'd31, "R11 dest 31", 64'(res_dest), 64'd31);
        issue(mk(5'd10, 5'b01100, 5'd31), '1, 1'b1);
        check(res_valid && res_dest == 5'd10, "R11 dest 10", 64'(res_dest), 64'd10);
    endtask

    task automatic t_idle();
        issue(mk(5'd1, 5'b01000, 5'd1), '1, 1'b1);
        @(negedge clk);
        check(!res_valid && !res_illegal, "R13 idle cycle",
              {62'd0, res_valid, res_illegal}, 64'd0);
    endtask

    task automatic t_back_to_back();
        logic [127:0] v = rnd128();
        @(negedge clk);
        insn_valid = 1'b1; insn = mk(5'd4, 5'b01000, 5'd6); vec = v; vec_en = 1'b1;
        @(negedge clk);
        expect_result("R2 first of pair", ref_mask(v, 0));
        vec_en = 1'b0;
        @(negedge clk);
        insn_valid = 1'b0; vec_en = 1'b1;
        check(res_illegal && !res_valid && res_data == 0, "R9 second of pair",
              res_data, 64'd0);
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        insn_valid = 1'b1; insn = mk(5'd4, 5'b01000, 5'd6); vec = '1; rst = 1'b1;
        @(negedge clk);
        check(!res_valid && !res_illegal, "R12 reset with instruction",
              {62'd0, res_valid, res_illegal}, 64'd0);
        rst = 1'b0; insn_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_alternate();
        t_random();
        t_body_bits();
        t_disabled();
        t_unhandled();
        t_dest();
        t_idle();
        t_back_to_back();
        t_reset_mid();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule